// File: doc/BRIEF.md
# Transfer-to-Beat Splitter

This block carries out one read or one write action of arbitrary length on a generic bus-master port. An action is described by a start address, a total byte count and a flag that pins the address. The block cuts the action into successive bus requests. Each request covers at most `MAX_BEAT` bytes. The final request carries whatever remains, including a tail that is not a whole data word.

Each chunk raises a request that presents an address and a byte size. The request stays up until the slave grants it. The block then waits for the slave's done strobe before it issues the next chunk. On writes it generates a byte pattern and pushes the chunk's words into the write channel whenever that channel is not full. On reads it ignores the returned words.

When the final chunk is done, the block pulses a completion flag back to the sequencer. An error strobe on the active channel aborts the action at once and is reported to the sequencer on a separate pulse.

Top module: `beat_splitter`

## Requirements
- R1: A `start` pulse is taken only while `busy` is low. `busy` is high from the next cycle until the action ends. A `start` pulse while `busy` is high has no effect on the requests issued.
- R2: Each chunk size equals min(remaining bytes, `MAX_BEAT`), and the chunk sizes add up to the action size. An action of size 0 issues no request and pulses `act_done` in the cycle after `start`.
- R3: A request stays asserted, with stable address and size, until its grant. No further request is raised until the granted chunk's done strobe has been seen.
- R4: With `act_fixed` low, each chunk's address is the previous chunk's address plus the previous chunk's size. With `act_fixed` high, every chunk uses the start address.
- R5: Write actions raise only `wr_req` and read actions raise only `rd_req`.
- R6: `act_done` is high for exactly one cycle, in the cycle after the final chunk's done strobe.
- R7: For a write chunk of S bytes, exactly ceil(S / (DATA_W/8)) words are pushed. `wr_push` is never high while `wr_full` is high. Consequently a 3-byte action pushes a single word.
- R8: Byte lane i of a pushed word sits at bits [8i+7:8i] and carries the low 8 bits of that byte's offset from the start of the action. Lanes that lie beyond the end of the chunk are zero.
- R9: An error strobe on the active channel ends the action. The next cycle has a one-cycle `act_err`, `busy` low, no request and no `act_done`. An error strobe on the inactive channel has no effect.
- R10: `rd_valid` and `rd_data` have no effect on requests, completion or write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an action (taken when idle) |
| act_write | input | 1 | 1 = write action, 0 = read action |
| act_addr | input | ADDR_W | Start address of the action |
| act_size | input | SIZE_W | Total bytes of the action |
| act_fixed | input | 1 | Keep the same address for every chunk |
| busy | output | 1 | Action in progress |
| act_done | output | 1 | One-cycle pulse: whole action finished |
| act_err | output | 1 | One-cycle pulse: action aborted by error |
| req_addr | output | ADDR_W | Address of the current chunk |
| req_size | output | SZW | Byte size of the current chunk |
| rd_req | output | 1 | Read chunk request |
| rd_grant | input | 1 | Read request accepted |
| rd_valid | input | 1 | Returned read word valid (discarded) |
| rd_data | input | DATA_W | Returned read word (discarded) |
| rd_done | input | 1 | Read chunk finished |
| rd_err | input | 1 | Read channel error |
| wr_req | output | 1 | Write chunk request |
| wr_grant | input | 1 | Write request accepted |
| wr_push | output | 1 | Write word valid this cycle |
| wr_data | output | DATA_W | Write word |
| wr_full | input | 1 | Write channel cannot take a word |
| wr_done | input | 1 | Write chunk finished |
| wr_err | input | 1 | Write channel error |

## Verification
The hardest situation to reach from the ports is the last write word of an oversized action. That word is partial and belongs to the remainder chunk, and the write channel is throttled while it is pushed. The stimulus reaches it with a write of `MAX_BEAT + 3` bytes while the responder holds `wr_full` high for two cycles out of every three. The lane pattern of each word is checked against its offset within the action.

An abort in the middle of an action is reached by having the responder answer the second chunk of a multi-chunk read with an error strobe instead of done. Strobes on the idle channel are raised on every cycle of a normal write to show they are ignored.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } split_state_t;
endpackage

// File: rtl/chunk_calc.sv
module chunk_calc #(
  parameter int SIZE_W   = 19,
  parameter int MAX_BEAT = 1024,
  parameter int SZW      = $clog2(MAX_BEAT + 1)
) (
  input  logic [SIZE_W-1:0] remaining,
  output logic [SZW-1:0]    chunk
);
  localparam logic [SIZE_W-1:0] MAXB = SIZE_W'(MAX_BEAT);

  always_comb begin
    if (remaining > MAXB) chunk = SZW'(MAX_BEAT);
    else                  chunk = remaining[SZW-1:0];
  end
endmodule

// File: rtl/wdata_gen.sv
module wdata_gen #(
  parameter int DATA_W   = 32,
  parameter int SIZE_W   = 19,
  parameter int MAX_BEAT = 1024,
  parameter int SZW      = $clog2(MAX_BEAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SIZE_W-1:0] load_ofs,
  input  logic [SZW-1:0]    load_bytes,
  input  logic              push,
  output logic              pending,
  output logic [DATA_W-1:0] data
);
  localparam int BYTES = DATA_W / 8;

  logic [SIZE_W-1:0] ofs_q;
  logic [SZW-1:0]    left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      ofs_q  <= load_ofs;
      left_q <= load_bytes;
    end else if (push) begin
      ofs_q  <= ofs_q + SIZE_W'(BYTES);
      left_q <= (left_q > SZW'(BYTES)) ? left_q - SZW'(BYTES) : '0;
    end
  end

  assign pending = (left_q != '0);

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    always_comb begin
      if (SZW'(i) < left_q) data[8*i +: 8] = ofs_q[7:0] + 8'(i);
      else                  data[8*i +: 8] = 8'h00;
    end
  end

  assert_push_pending_R7: assert property (@(posedge clk) disable iff (rst)
    push |-> pending);
endmodule

// File: rtl/beat_splitter.sv
module beat_splitter
  import splitter_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 19,
  parameter int MAX_BEAT = 1024,
  parameter int SZW      = $clog2(MAX_BEAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              act_write,
  input  logic [ADDR_W-1:0] act_addr,
  input  logic [SIZE_W-1:0] act_size,
  input  logic              act_fixed,
  output logic              busy,
  output logic              act_done,
  output logic              act_err,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SZW-1:0]    req_size,
  output logic              rd_req,
  input  logic              rd_grant,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_done,
  input  logic              rd_err,
  output logic              wr_req,
  input  logic              wr_grant,
  output logic              wr_push,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_full,
  input  logic              wr_done,
  input  logic              wr_err
);
  split_state_t      state_q;
  logic              wr_q, fix_q, done_q, err_q;
  logic [ADDR_W-1:0] base_q, addr_q;
  logic [SIZE_W-1:0] rem_q, sent_q;
  logic [SZW-1:0]    size_q;

  logic [SIZE_W-1:0] rem_after, calc_in;
  logic [SZW-1:0]    next_chunk;
  logic              grant_hit, done_hit, err_hit, gen_pending, gen_load;

  assign rem_after = rem_q - SIZE_W'(size_q);
  assign calc_in   = (state_q == ST_IDLE) ? act_size : rem_after;
  assign grant_hit = wr_q ? wr_grant : rd_grant;
  assign done_hit  = wr_q ? wr_done  : rd_done;
  assign err_hit   = wr_q ? wr_err   : rd_err;
  assign gen_load  = (state_q == ST_REQ) && grant_hit && !err_hit;

  chunk_calc #(.SIZE_W(SIZE_W), .MAX_BEAT(MAX_BEAT), .SZW(SZW)) u_calc (
    .remaining (calc_in),
    .chunk     (next_chunk)
  );

  wdata_gen #(.DATA_W(DATA_W), .SIZE_W(SIZE_W), .MAX_BEAT(MAX_BEAT), .SZW(SZW)) u_gen (
    .clk        (clk),
    .rst        (rst),
    .load       (gen_load),
    .load_ofs   (sent_q),
    .load_bytes (size_q),
    .push       (wr_push),
    .pending    (gen_pending),
    .data       (wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      fix_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      base_q  <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      sent_q  <= '0;
      size_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            wr_q   <= act_write;
            fix_q  <= act_fixed;
            base_q <= act_addr;
            addr_q <= act_addr;
            rem_q  <= act_size;
            sent_q <= '0;
            size_q <= next_chunk;
            if (act_size == '0) done_q  <= 1'b1;
            else                state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (err_hit) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (grant_hit) begin
            state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (err_hit) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (done_hit) begin
            rem_q  <= rem_after;
            sent_q <= sent_q + SIZE_W'(size_q);
            size_q <= next_chunk;
            if (!fix_q) addr_q <= addr_q + ADDR_W'(size_q);
            if (rem_after == '0) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign act_done = done_q;
  assign act_err  = err_q;
  assign req_addr = addr_q;
  assign req_size = size_q;
  assign rd_req   = (state_q == ST_REQ) && !wr_q;
  assign wr_req   = (state_q == ST_REQ) && wr_q;
  assign wr_push  = (state_q == ST_XFER) && wr_q && gen_pending && !wr_full;

  assert_size_range_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req || wr_req) |-> (req_size != '0) && (req_size <= SZW'(MAX_BEAT)));

  assert_wr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_grant && !wr_err) |=> wr_req && $stable(req_addr) && $stable(req_size));

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_grant && !rd_err) |=> rd_req && $stable(req_addr) && $stable(req_size));

  assert_fixed_addr_R4: assert property (@(posedge clk) disable iff (rst)
    ((rd_req || wr_req) && fix_q) |-> (req_addr == base_q));

  assert_one_channel_R5: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    act_done |=> !act_done);

  assert_no_push_full_R7: assert property (@(posedge clk) disable iff (rst)
    wr_push |-> !wr_full);

  assert_err_abort_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && err_hit) |=> act_err && !busy && !act_done);

  assert_rd_data_known_R10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !$isunknown(rd_data));
endmodule

// File: tb/beat_splitter_test.sv
module beat_splitter_test;
  localparam int DATA_W = 32, ADDR_W = 32, SIZE_W = 19, MAXB = 1024;
  localparam int SZW = $clog2(MAXB + 1);
  localparam int B = DATA_W / 8;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, act_write = 0, act_fixed = 0;
  logic [ADDR_W-1:0] act_addr = '0;
  logic [SIZE_W-1:0] act_size = '0;
  logic busy, act_done, act_err, rd_req, wr_req, wr_push;
  logic [ADDR_W-1:0] req_addr;
  logic [SZW-1:0] req_size;
  logic [DATA_W-1:0] wr_data, rd_data = '0;
  logic rd_grant = 0, rd_valid = 0, rd_done = 0, rd_err = 0;
  logic wr_grant = 0, wr_full = 0, wr_done = 0, wr_err = 0;

  always #4 clk = ~clk;

  beat_splitter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_BEAT(MAXB)) uut (
    .clk(clk), .rst(rst), .start(start), .act_write(act_write), .act_addr(act_addr),
    .act_size(act_size), .act_fixed(act_fixed), .busy(busy), .act_done(act_done),
    .act_err(act_err), .req_addr(req_addr), .req_size(req_size), .rd_req(rd_req),
    .rd_grant(rd_grant), .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done),
    .rd_err(rd_err), .wr_req(wr_req), .wr_grant(wr_grant), .wr_push(wr_push),
    .wr_data(wr_data), .wr_full(wr_full), .wr_done(wr_done), .wr_err(wr_err));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // responder state
  int cyc = 0, gcnt = 0, xcyc = 0, words_got = 0, words_exp = 0;
  int n_chunks = 0, word_total = 0, pat_bad = 0, last_done_cyc = 0;
  int gdly = 0, err_chunk = -1, exp_total = 0;
  bit full_mode = 0, noise = 0, cur_write = 0, in_xfer = 0, wrong_chan = 0;
  logic [ADDR_W-1:0] ch_addr [0:15];
  int ch_size [0:15];

  always @(negedge clk) begin
    cyc++;
    rd_done = 0; wr_done = 0; rd_err = 0; wr_err = 0; rd_grant = 0; wr_grant = 0;
    if (!rst) begin
      if (in_xfer) begin
        xcyc++;
        if (err_chunk == n_chunks - 1 && xcyc >= 2) begin
          if (cur_write) wr_err = 1; else rd_err = 1;
          in_xfer = 0;
        end else if (cur_write ? (words_got >= words_exp && xcyc >= 2) : (xcyc >= 3)) begin
          if (cur_write) wr_done = 1; else rd_done = 1;
          in_xfer = 0;
          last_done_cyc = cyc;
        end
      end else if (rd_req || wr_req) begin
        if (gcnt >= gdly) begin
          if (wr_req) wr_grant = 1; else rd_grant = 1;
          gcnt = 0;
        end else gcnt++;
      end
      wr_full = full_mode && (cyc % 3 != 0);
      rd_valid = in_xfer && !cur_write && cyc[0];
      rd_data = cyc;
      if (noise) begin
        if (cur_write) rd_err = 1; else wr_err = 1;
      end
    end
    #1;
    if ((cur_write && rd_req) || (!cur_write && wr_req)) wrong_chan = 1;
    if ((rd_req && rd_grant) || (wr_req && wr_grant)) begin
      if (n_chunks < 16) begin
        ch_addr[n_chunks] = req_addr;
        ch_size[n_chunks] = int'(req_size);
      end
      n_chunks++;
      in_xfer = 1; xcyc = 0; words_got = 0;
      words_exp = (int'(req_size) + B - 1) / B;
    end
    if (wr_push) begin
      for (int i = 0; i < B; i++) begin
        int o;
        logic [7:0] e;
        o = word_total * B + i;
        e = (o < exp_total) ? 8'(o) : 8'h00;
        if (wr_data[8*i +: 8] !== e) pat_bad++;
      end
      word_total++;
      words_got++;
    end
  end

  // runs one action; returns completion cycle (0 if none) and error flag
  task automatic run(input bit w, input logic [31:0] a, input int sz, input bit fx,
                     input int gd, input bit fm, input int ec, input bit nz,
                     input bit restart, output int dcyc, output bit gerr, output int scyc);
    n_chunks = 0; word_total = 0; pat_bad = 0; wrong_chan = 0;
    gdly = gd; full_mode = fm; err_chunk = ec; noise = nz; cur_write = w; exp_total = sz;
    dcyc = 0; gerr = 0;
    @(negedge clk); #2;
    start = 1; act_write = w; act_addr = a; act_size = SIZE_W'(sz); act_fixed = fx;
    scyc = cyc;
    @(negedge clk); #2;
    start = 0;
    if (sz != 0) chk(busy === 1'b1, "R1", "busy after start", busy, 1);
    for (int t = 0; t < 20000 && dcyc == 0 && !gerr; t++) begin
      if (t > 0) begin @(negedge clk); #2; end
      if (restart && t == 5) begin
        start = 1; act_write = !w; act_addr = 32'hDEAD_0000; act_size = 7; act_fixed = 0;
      end else start = 0;
      if (act_done) dcyc = cyc;
      if (act_err) gerr = 1;
    end
    @(negedge clk); #2;
    chk(act_done === 1'b0 && act_err === 1'b0, "R6", "pulse width", act_done, 0);
    chk(busy === 1'b0, "R1", "busy after end", busy, 0);
    noise = 0; full_mode = 0;
  endtask

  task automatic check_chunks(input logic [31:0] a, input int sz, input bit fx, input bit w);
    int rem, s, k;
    logic [31:0] ad;
    rem = sz; ad = a; k = 0;
    while (rem > 0) begin
      s = (rem > MAXB) ? MAXB : rem;
      chk(ch_size[k] == s, "R2", "chunk size", ch_size[k], s);
      chk(ch_addr[k] == ad, "R4", "chunk addr", ch_addr[k], ad);
      if (!fx) ad += s;
      rem -= s; k++;
    end
    chk(n_chunks == k, "R2", "chunk count", n_chunks, k);
    chk(!wrong_chan, "R5", "channel select", wrong_chan, 0);
    if (w) begin
      chk(word_total == (sz + B - 1) / B, "R7", "words pushed", word_total, (sz + B - 1) / B);
      chk(pat_bad == 0, "R8", "lane pattern errors", pat_bad, 0);
    end else chk(word_total == 0, "R10", "no pushes on read", word_total, 0);
  endtask

  task automatic t_reset();
    chk(busy === 0 && rd_req === 0 && wr_req === 0, "R1", "idle after reset", busy, 0);
    chk(act_done === 0 && act_err === 0 && wr_push === 0, "R6", "no pulses after reset", act_done, 0);
  endtask

  task automatic t_zero();
    int d, s; bit e;
    run(1, 32'h100, 0, 0, 0, 0, -1, 0, 0, d, e, s);
    chk(d == s + 1, "R2", "zero-size done cycle", d, s + 1);
    chk(n_chunks == 0, "R2", "zero-size no request", n_chunks, 0);
  endtask

  task automatic t_write(input logic [31:0] a, input int sz, input bit fx, input int gd, input bit fm, input bit nz);
    int d, s; bit e;
    run(1, a, sz, fx, gd, fm, -1, nz, 0, d, e, s);
    chk(!e, "R9", "no error", e, 0);
    chk(d == last_done_cyc + 1, "R6", "done after last chunk", d, last_done_cyc + 1);
    check_chunks(a, sz, fx, 1);
  endtask

  task automatic t_read(input logic [31:0] a, input int sz, input bit fx, input int gd, input bit rs);
    int d, s; bit e;
    run(0, a, sz, fx, gd, 0, -1, 0, rs, d, e, s);
    chk(!e, "R9", "no error", e, 0);
    chk(d == last_done_cyc + 1, "R6", "done after last chunk", d, last_done_cyc + 1);
    check_chunks(a, sz, fx, 0);
  endtask

  task automatic t_error();
    int d, s; bit e;
    run(0, 32'h4000, 3000, 0, 1, 0, 1, 0, 0, d, e, s);
    chk(e, "R9", "error reported", e, 1);
    chk(d == 0, "R9", "no completion after error", d, 0);
    chk(n_chunks == 2, "R9", "chunks before abort", n_chunks, 2);
    chk(rd_req === 0 && wr_req === 0, "R9", "requests dropped", rd_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #2;
    t_reset();
    t_zero();
    t_write(32'h1000, MAXB - 3, 0, 0, 0, 0);  // below max: R2, R8
    t_write(32'h2000, MAXB, 0, 2, 0, 0);      // exactly max
    t_write(32'h3000, MAXB + 3, 0, 1, 1, 0);  // above max, throttled: R7
    t_read(32'h5000, MAXB + 3, 1, 3, 0);      // fixed address read: R4
    t_write(32'h6000, 3, 1, 0, 0, 0);         // partial word: R7
    t_read(32'h7000, 2500, 0, 0, 1);          // start while busy: R1
    t_write(32'h8000, 4100, 1, 0, 0, 1);      // inactive channel errors ignored: R9
    t_error();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule